// File: doc/BRIEF.md
# Flag-producing ALU with branch test

This block is an integer execution unit that takes one operation per clock and keeps a four-bit status word. The status word holds sign (S), zero (Z), overflow (O) and carry (C). An operation is offered on `op_code` with `op_valid` high and completes at the next rising edge. At that edge the destination value, when the operation writes one, is registered on `result` with a one-cycle `result_we` pulse, and the status word is updated. Each operation has its own rule for which flags it changes.

The operations are:
- addition, with or without carry-in;
- subtraction, with or without borrow-in;
- compare;
- AND, OR, XOR and test;
- increment, decrement and negate;
- a bit group that reads one bit into carry, optionally setting, clearing or flipping it;
- three carry controls.

Operands are 32 bits wide. `byte_mode` restricts an operation to the low 8 bits.

A separate combinational path compares a 4-bit condition selector with the registered flags and drives `taken`. A branch unit can use this the cycle after any flag-writing operation. The block has no state machine. Every operation finishes in the cycle it is accepted, and the only state is the result, write strobe and flags registers.

Top module: `flag_alu`

## Requirements
- R1: While `rst_n` is low, and after it is released, `flags`, `result` and `result_we` are all zero until the first operation.
- R2: Opcode 0 (add) and 1 (add with carry) register dst+src (+C for opcode 1). C is set to the unsigned carry-out. O is set when both operands have the same sign and the result sign differs. S is the result sign. Z is set when the result is zero.
- R3: Opcode 2 (subtract), 3 (subtract with borrow, minus C) and 11 (negate, computes 0−dst) register the difference. C is set to the unsigned borrow. O is set when the operand signs differ and the result sign differs from the minuend. S and Z follow the result.
- R4: Opcode 4 (compare, as subtract) and 8 (test, as AND) update flags exactly like their counterparts. They keep `result_we` low and leave `result` unchanged.
- R5: Opcodes 5 (AND), 6 (OR) and 7 (XOR) register the result, set S and Z from it, and clear O and C.
- R6: Opcodes 9 (increment) and 10 (decrement) register dst±1 and update S, Z and O. C keeps its previous value.
- R7: Opcodes 12 to 15 select bit index src modulo the operand width (32, or 8 in byte mode) and copy that bit of dst into C. S, Z and O are kept. Opcode 12 writes nothing. Opcode 13 registers dst with the bit set, 14 with it cleared, and 15 with it inverted.
- R8: Opcode 16 clears C, 17 sets C and 18 inverts C. The other flags and `result` are unchanged, and `result_we` stays low.
- R9: With `byte_mode` high, only bits 7:0 of the operands are used. S, O and C are taken at bit 7, and `result` bits 31:8 are zero.
- R10: `taken` decodes `cond_sel` as follows:
  - 0 O / 1 not O
  - 2 C / 3 not C
  - 4 Z / 5 not Z
  - 6 (C|Z) / 7 not (C|Z)
  - 8 S / 9 not S
  - 10 always / 11 never
  - 12 S^O / 13 not (S^O)
  - 14 Z|(S^O) / 15 not (Z|(S^O))
- R11: When `op_valid` is low, or the opcode is above 18, the flags and `result` are unchanged and `result_we` stays low.
- R12: `taken` is evaluated from the registered flags. In the cycle an operation is presented it reflects the flags from before that operation. From the following cycle on it reflects the updated flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation selector |
| byte_mode | input | 1 | Operate on bits 7:0 only |
| dst_val | input | 32 | Destination operand (minuend, bit-group source) |
| src_val | input | 32 | Source operand (subtrahend, bit index) |
| cond_sel | input | 4 | Branch condition selector |
| result | output | 32 | Registered destination value |
| result_we | output | 1 | Destination written by the last accepted operation |
| flags | output | 4 | Registered {S, Z, O, C} |
| taken | output | 1 | Condition outcome against the registered flags |

## Verification
Two things can happen in one cycle: the branch test reads the flags while a flag-writing operation is updating them. The bench sets up this overlap by changing `cond_sel` together with every new operation. Each check compares `taken` against the reference flags of the operation that has just retired, never against those of the operation still in flight. The bench also runs all 16 conditions against four different flag states, and it follows carry through runs of increment, decrement and the bit group. This shows that carry is kept at the points where it is required to be kept.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    localparam int DATA_W   = 32;
    localparam int NARROW_W = 8;
    localparam int OP_W     = 5;
    localparam int COND_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 5'd0,
        OP_ADC = 5'd1,
        OP_SUB = 5'd2,
        OP_SBB = 5'd3,
        OP_CMP = 5'd4,
        OP_AND = 5'd5,
        OP_OR  = 5'd6,
        OP_XOR = 5'd7,
        OP_TST = 5'd8,
        OP_INC = 5'd9,
        OP_DEC = 5'd10,
        OP_NEG = 5'd11,
        OP_BT  = 5'd12,
        OP_BTS = 5'd13,
        OP_BTR = 5'd14,
        OP_BTC = 5'd15,
        OP_CLC = 5'd16,
        OP_STC = 5'd17,
        OP_CMC = 5'd18
    } op_e;

    typedef enum logic [COND_W-1:0] {
        CC_OV   = 4'd0,
        CC_NOV  = 4'd1,
        CC_CY   = 4'd2,
        CC_NCY  = 4'd3,
        CC_EQ   = 4'd4,
        CC_NE   = 4'd5,
        CC_ULE  = 4'd6,
        CC_UGT  = 4'd7,
        CC_NEG  = 4'd8,
        CC_POS  = 4'd9,
        CC_ALW  = 4'd10,
        CC_NEV  = 4'd11,
        CC_SLT  = 4'd12,
        CC_SGE  = 4'd13,
        CC_SLE  = 4'd14,
        CC_SGT  = 4'd15
    } cond_e;

    typedef struct packed {
        logic s;
        logic z;
        logic o;
        logic c;
    } flags_t;

endpackage

// File: rtl/flag_alu_addsub.sv
module flag_alu_addsub
    import flag_alu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int NW = NARROW_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    input  logic         narrow,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         ovf,
    output logic         msb
);

    logic [W:0] am;
    logic [W:0] bm;
    logic [W:0] full;
    logic       sa;
    logic       sb;

    always_comb begin
        am = narrow ? {{(W+1-NW){1'b0}}, a[NW-1:0]} : {1'b0, a};
        bm = narrow ? {{(W+1-NW){1'b0}}, b[NW-1:0]} : {1'b0, b};
        if (sub) begin
            full = am - bm - {{W{1'b0}}, cin};
        end else begin
            full = am + bm + {{W{1'b0}}, cin};
        end
        res  = narrow ? {{(W-NW){1'b0}}, full[NW-1:0]} : full[W-1:0];
        cout = narrow ? full[NW] : full[W];
        msb  = narrow ? full[NW-1] : full[W-1];
        sa   = narrow ? a[NW-1] : a[W-1];
        sb   = narrow ? b[NW-1] : b[W-1];
        if (sub) begin
            ovf = (sa != sb) && (msb != sa);
        end else begin
            ovf = (sa == sb) && (msb != sa);
        end
    end

endmodule

// File: rtl/flag_alu_bitlogic.sv
module flag_alu_bitlogic
    import flag_alu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int NW = NARROW_W
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         narrow,
    output logic [W-1:0] res,
    output logic         msb,
    output logic         sel_bit
);

    localparam int IW  = $clog2(W);
    localparam int NIW = $clog2(NW);

    logic [IW-1:0] idx;
    logic [W-1:0]  onehot;
    logic [W-1:0]  keep;
    logic [W-1:0]  raw;

    assign idx = narrow ? {{(IW-NIW){1'b0}}, b[NIW-1:0]} : b[IW-1:0];

    for (genvar i = 0; i < W; i++) begin : g_sel
        assign onehot[i] = (idx == IW'(i));
    end

    assign keep    = narrow ? {{(W-NW){1'b0}}, {NW{1'b1}}} : {W{1'b1}};
    assign sel_bit = |(a & onehot);

    always_comb begin
        unique case (op)
            OP_OR:   raw = a | b;
            OP_XOR:  raw = a ^ b;
            OP_BTS:  raw = a | onehot;
            OP_BTR:  raw = a & ~onehot;
            OP_BTC:  raw = a ^ onehot;
            default: raw = a & b;
        endcase
        res = raw & keep;
        msb = narrow ? res[NW-1] : res[W-1];
    end

endmodule

// File: rtl/flag_alu_cond.sv
module flag_alu_cond
    import flag_alu_pkg::*;
(
    input  flags_t              fl,
    input  logic [COND_W-1:0]   cond,
    output logic                taken
);

    logic lt;

    always_comb begin
        lt = fl.s ^ fl.o;
        unique case (cond_e'(cond))
            CC_OV:  taken = fl.o;
            CC_NOV: taken = !fl.o;
            CC_CY:  taken = fl.c;
            CC_NCY: taken = !fl.c;
            CC_EQ:  taken = fl.z;
            CC_NE:  taken = !fl.z;
            CC_ULE: taken = fl.c | fl.z;
            CC_UGT: taken = !(fl.c | fl.z);
            CC_NEG: taken = fl.s;
            CC_POS: taken = !fl.s;
            CC_ALW: taken = 1'b1;
            CC_NEV: taken = 1'b0;
            CC_SLT: taken = lt;
            CC_SGE: taken = !lt;
            CC_SLE: taken = fl.z | lt;
            CC_SGT: taken = !(fl.z | lt);
        endcase
    end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int NW = NARROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic              byte_mode,
    input  logic [W-1:0]      dst_val,
    input  logic [W-1:0]      src_val,
    input  logic [COND_W-1:0] cond_sel,
    output logic [W-1:0]      result,
    output logic              result_we,
    output logic [3:0]        flags,
    output logic              taken
);

    op_e          op;
    flags_t       fl_q;
    flags_t       fl_d;
    logic [W-1:0] res_q;
    logic [W-1:0] res_d;
    logic         we_q;
    logic         we_d;

    logic [W-1:0] as_a;
    logic [W-1:0] as_b;
    logic         as_cin;
    logic         as_sub;
    logic [W-1:0] as_res;
    logic         as_cout;
    logic         as_ovf;
    logic         as_msb;

    logic [W-1:0] lg_res;
    logic         lg_msb;
    logic         lg_bit;

    assign op = op_e'(op_code);

    // Operand steering for the shared adder/subtractor
    always_comb begin
        as_a   = dst_val;
        as_b   = src_val;
        as_cin = 1'b0;
        as_sub = 1'b0;
        unique case (op)
            OP_ADC: as_cin = fl_q.c;
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBB: begin
                as_sub = 1'b1;
                as_cin = fl_q.c;
            end
            OP_INC: as_b = {{(W-1){1'b0}}, 1'b1};
            OP_DEC: begin
                as_b   = {{(W-1){1'b0}}, 1'b1};
                as_sub = 1'b1;
            end
            OP_NEG: begin
                as_a   = '0;
                as_b   = dst_val;
                as_sub = 1'b1;
            end
            default: ;
        endcase
    end

    flag_alu_addsub #(.W(W), .NW(NW)) u_addsub (
        .a      (as_a),
        .b      (as_b),
        .cin    (as_cin),
        .sub    (as_sub),
        .narrow (byte_mode),
        .res    (as_res),
        .cout   (as_cout),
        .ovf    (as_ovf),
        .msb    (as_msb)
    );

    flag_alu_bitlogic #(.W(W), .NW(NW)) u_bitlogic (
        .op      (op),
        .a       (dst_val),
        .b       (src_val),
        .narrow  (byte_mode),
        .res     (lg_res),
        .msb     (lg_msb),
        .sel_bit (lg_bit)
    );

    flag_alu_cond u_cond (
        .fl    (fl_q),
        .cond  (cond_sel),
        .taken (taken)
    );

    // Next-state selection: per-operation flag rules
    always_comb begin
        fl_d  = fl_q;
        res_d = res_q;
        we_d  = 1'b0;
        if (op_valid) begin
            unique case (op)
                OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_NEG: begin
                    res_d = as_res;
                    we_d  = 1'b1;
                    fl_d  = '{s: as_msb, z: (as_res == '0), o: as_ovf, c: as_cout};
                end
                OP_CMP: begin
                    fl_d = '{s: as_msb, z: (as_res == '0), o: as_ovf, c: as_cout};
                end
                OP_INC, OP_DEC: begin
                    res_d  = as_res;
                    we_d   = 1'b1;
                    fl_d.s = as_msb;
                    fl_d.z = (as_res == '0);
                    fl_d.o = as_ovf;
                end
                OP_AND, OP_OR, OP_XOR: begin
                    res_d = lg_res;
                    we_d  = 1'b1;
                    fl_d  = '{s: lg_msb, z: (lg_res == '0), o: 1'b0, c: 1'b0};
                end
                OP_TST: begin
                    fl_d = '{s: lg_msb, z: (lg_res == '0), o: 1'b0, c: 1'b0};
                end
                OP_BT: begin
                    fl_d.c = lg_bit;
                end
                OP_BTS, OP_BTR, OP_BTC: begin
                    res_d  = lg_res;
                    we_d   = 1'b1;
                    fl_d.c = lg_bit;
                end
                OP_CLC: fl_d.c = 1'b0;
                OP_STC: fl_d.c = 1'b1;
                OP_CMC: fl_d.c = !fl_q.c;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q  <= '0;
            res_q <= '0;
            we_q  <= 1'b0;
        end else begin
            fl_q  <= fl_d;
            res_q <= res_d;
            we_q  <= we_d;
        end
    end

    assign result    = res_q;
    assign result_we = we_q;
    assign flags     = fl_q;

    // R5: logic operations leave O and C cleared
    p_logic_clears_oc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_TST))
        |=> (flags[1:0] == 2'b00));

    // R6: increment and decrement keep carry
    p_incdec_keeps_c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_INC || op == OP_DEC)) |=> (flags[0] == $past(flags[0])));

    // R4: compare and test do not write the destination
    p_cmp_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_CMP || op == OP_TST)) |=> (!result_we && $stable(result)));

    // R11: idle cycles hold all state
    p_idle_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(flags) && $stable(result) && !result_we));

    // R8: clear-carry leaves C low and S, Z, O untouched
    p_clc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_CLC) |=> (!flags[0] && flags[3:1] == $past(flags[3:1])));

endmodule

// File: tb/tb_flag_alu.sv
`timescale 1ns/1ps
module tb_flag_alu;

    typedef struct {
        logic [31:0] res;
        logic        we;
        logic [3:0]  fl;
        int          due;
        int          req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic        byte_mode = 1'b0;
    logic [31:0] dst_val = '0;
    logic [31:0] src_val = '0;
    logic [3:0]  cond_sel = '0;
    logic [31:0] result;
    logic        result_we;
    logic [3:0]  flags;
    logic        taken;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    done = 0;
    item_t q[$];
    logic [3:0]  m_fl = '0;
    logic [31:0] m_res = '0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    flag_alu dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .byte_mode(byte_mode), .dst_val(dst_val), .src_val(src_val),
        .cond_sel(cond_sel), .result(result), .result_we(result_we),
        .flags(flags), .taken(taken)
    );

    // Reference condition decode (R10)
    function automatic logic ref_taken(input logic [3:0] cc, input logic [3:0] f);
        logic s, z, o, c;
        {s, z, o, c} = f;
        case (cc)
            4'd0: return o;          4'd1: return !o;
            4'd2: return c;          4'd3: return !c;
            4'd4: return z;          4'd5: return !z;
            4'd6: return c | z;      4'd7: return !(c | z);
            4'd8: return s;          4'd9: return !s;
            4'd10: return 1'b1;      4'd11: return 1'b0;
            4'd12: return s ^ o;     4'd13: return !(s ^ o);
            4'd14: return z | (s ^ o);
            default: return !(z | (s ^ o));
        endcase
    endfunction

    // Reference operation model from the requirements
    task automatic model(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic bm, output logic [31:0] r_o, output logic we_o,
                         output logic [3:0] fl_o);
        logic [63:0] mask, aa, bb, r, ci;
        int sh, idx;
        logic s, z, o, c, sa, sb;
        mask = bm ? 64'hFF : 64'hFFFF_FFFF;
        sh   = bm ? 7 : 31;
        aa   = {32'd0, a} & mask;
        bb   = {32'd0, b} & mask;
        {s, z, o, c} = m_fl;
        r_o  = m_res;
        we_o = 1'b0;
        ci   = {63'd0, m_fl[0]};
        case (op)
            5'd0, 5'd1, 5'd9: begin
                if (op == 5'd9) bb = 64'd1;
                if (op == 5'd0 || op == 5'd9) ci = 0;
                r  = aa + bb + ci;
                sa = aa[sh]; sb = bb[sh];
                if (op != 5'd9) c = r[sh+1];
                r  = r & mask;
                o  = (sa == sb) && (r[sh] != sa);
                s  = r[sh]; z = (r == 0);
                r_o = r[31:0]; we_o = 1;
            end
            5'd2, 5'd3, 5'd4, 5'd10, 5'd11: begin
                if (op == 5'd10) bb = 64'd1;
                if (op == 5'd11) begin bb = aa; aa = 0; end
                if (op != 5'd3) ci = 0;
                if (op != 5'd10) c = (aa < bb + ci);
                r  = (aa - bb - ci) & mask;
                sa = aa[sh]; sb = bb[sh];
                o  = (sa != sb) && (r[sh] != sa);
                s  = r[sh]; z = (r == 0);
                if (op != 5'd4) begin r_o = r[31:0]; we_o = 1; end
            end
            5'd5, 5'd6, 5'd7, 5'd8: begin
                r = (op == 5'd6) ? (aa | bb) : (op == 5'd7) ? (aa ^ bb) : (aa & bb);
                s = r[sh]; z = (r == 0); o = 0; c = 0;
                if (op != 5'd8) begin r_o = r[31:0]; we_o = 1; end
            end
            5'd12, 5'd13, 5'd14, 5'd15: begin
                idx = int'(b % (bm ? 32'd8 : 32'd32));
                c = aa[idx];
                r = aa;
                if (op == 5'd13) r[idx] = 1'b1;
                if (op == 5'd14) r[idx] = 1'b0;
                if (op == 5'd15) r[idx] = !r[idx];
                if (op != 5'd12) begin r_o = r[31:0]; we_o = 1; end
            end
            5'd16: c = 0;
            5'd17: c = 1;
            5'd18: c = !c;
            default: ;
        endcase
        fl_o = {s, z, o, c};
    endtask

    // Driver: presents one cycle of stimulus and pushes the expected outcome
    task automatic drive(input logic v, input logic [4:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic bm, input logic [3:0] cc,
                         input int req);
        item_t it;
        logic [31:0] r;
        logic w;
        logic [3:0] f;
        @(posedge clk);
        #1;
        op_valid = v; op_code = op; dst_val = a; src_val = b; byte_mode = bm; cond_sel = cc;
        if (v) model(op, a, b, bm, r, w, f);
        else begin r = m_res; w = 0; f = m_fl; end
        m_fl = f; m_res = r;
        it.res = r; it.we = w; it.fl = f; it.due = cyc + 1; it.req = req;
        q.push_back(it);
    endtask

    task automatic op1(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input int req);
        drive(1'b1, op, a, b, 1'b0, 4'd10, req);
    endtask

    task automatic opb(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input int req);
        drive(1'b1, op, a, b, 1'b1, 4'd10, req);
    endtask

    // Monitor: compares outputs once the item's capture edge has passed (R12 timing)
    always @(negedge clk) begin
        if (q.size() > 0 && cyc >= q[0].due) begin
            item_t it;
            logic exp_t;
            it = q.pop_front();
            checks++;
            if (result !== it.res || result_we !== it.we || flags !== it.fl) begin
                errors++;
                $display("FAIL R%0d: result=%h we=%b flags=%b expected result=%h we=%b flags=%b",
                         it.req, result, result_we, flags, it.res, it.we, it.fl);
            end
            exp_t = ref_taken(cond_sel, it.fl);
            checks++;
            if (taken !== exp_t) begin
                errors++;
                $display("FAIL R12/R10: cond=%0d taken=%b expected %b (flags %b)",
                         cond_sel, taken, exp_t, it.fl);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        checks++;
        if (flags !== 4'b0 || result !== 32'b0 || result_we !== 1'b0) begin
            errors++;
            $display("FAIL R1: flags=%b result=%h we=%b expected 0 0 0", flags, result, result_we);
        end
        @(posedge clk); #1; rst_n = 1'b1;

        // R2: add, carry-out, overflow, add with carry
        op1(5'd0, 32'hFFFF_FFFF, 32'h1, 2);
        op1(5'd0, 32'h7FFF_FFFF, 32'h1, 2);
        op1(5'd0, 32'hFFFF_FFFF, 32'h2, 2);
        op1(5'd1, 32'h10, 32'h20, 2);
        op1(5'd1, 32'h7FFF_FFFF, 32'h0, 2);

        // R3: subtract, borrow, overflow, negate
        op1(5'd2, 32'h1, 32'h2, 3);
        op1(5'd2, 32'h8000_0000, 32'h1, 3);
        op1(5'd17, 0, 0, 8);
        op1(5'd3, 32'h5, 32'h5, 3);
        op1(5'd3, 32'h9, 32'h4, 3);
        op1(5'd11, 32'h0, 0, 3);
        op1(5'd11, 32'h8000_0000, 0, 3);
        op1(5'd11, 32'h5, 0, 3);

        // R4: compare and test do not write
        op1(5'd4, 32'h5, 32'h5, 4);
        op1(5'd4, 32'h3, 32'h7, 4);
        op1(5'd8, 32'hF0, 32'h0F, 4);
        op1(5'd8, 32'h8000_0000, 32'hFFFF_FFFF, 4);

        // R5: logic ops clear O and C
        op1(5'd17, 0, 0, 8);
        op1(5'd0, 32'h7FFF_FFFF, 32'h1, 2);
        op1(5'd5, 32'h8000_0001, 32'hFFFF_FFFF, 5);
        op1(5'd17, 0, 0, 8);
        op1(5'd6, 32'h0, 32'h0, 5);
        op1(5'd7, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 5);

        // R6: increment and decrement keep carry
        op1(5'd17, 0, 0, 8);
        op1(5'd9, 32'h7FFF_FFFF, 0, 6);
        op1(5'd9, 32'hFFFF_FFFF, 0, 6);
        op1(5'd16, 0, 0, 8);
        op1(5'd10, 32'h0, 0, 6);
        op1(5'd10, 32'h8000_0000, 0, 6);

        // R7: bit group with modulo index
        op1(5'd12, 32'h8, 32'd35, 7);
        op1(5'd13, 32'h0, 32'd31, 7);
        op1(5'd14, 32'hFFFF_FFFF, 32'd4, 7);
        op1(5'd15, 32'hF0, 32'd68, 7);
        op1(5'd15, 32'h0, 32'd0, 7);

        // R8: carry controls
        op1(5'd0, 32'h7FFF_FFFF, 32'h1, 8);
        op1(5'd16, 0, 0, 8);
        op1(5'd17, 0, 0, 8);
        op1(5'd18, 0, 0, 8);
        op1(5'd18, 0, 0, 8);

        // R9: byte mode
        opb(5'd0, 32'hABCD_00FF, 32'hFFFF_FF01, 9);
        opb(5'd2, 32'h1234_5680, 32'h1, 9);
        opb(5'd9, 32'hFFFF_FF7F, 0, 9);
        opb(5'd13, 32'hFFFF_FF00, 32'd11, 9);
        opb(5'd5, 32'h1234_5680, 32'hFFFF_FFFF, 9);
        opb(5'd11, 32'h0000_0001, 0, 9);

        // R11: idle and unused opcodes hold state
        drive(1'b0, 5'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 4'd0, 11);
        op1(5'd25, 32'hFFFF_FFFF, 32'h1, 11);
        op1(5'd31, 32'h0, 32'h0, 11);

        // R10/R12: all conditions against four flag states
        op1(5'd4, 32'h5, 32'h5, 10);
        for (int i = 0; i < 16; i++) drive(1'b0, 5'd0, 0, 0, 1'b0, i[3:0], 10);
        op1(5'd2, 32'h1, 32'h2, 10);
        for (int i = 0; i < 16; i++) drive(1'b0, 5'd0, 0, 0, 1'b0, i[3:0], 10);
        op1(5'd0, 32'h7FFF_FFFF, 32'h1, 10);
        for (int i = 0; i < 16; i++) drive(1'b0, 5'd0, 0, 0, 1'b0, i[3:0], 10);
        op1(5'd4, 32'h2, 32'h1, 10);
        for (int i = 0; i < 16; i++) drive(1'b0, 5'd0, 0, 0, 1'b0, i[3:0], 10);
        // R12: back-to-back flag writers with conditions changing each cycle
        for (int i = 0; i < 16; i++)
            drive(1'b1, 5'd2, 32'(i), 32'd7, 1'b0, i[3:0], 12);

        repeat (3) drive(1'b0, 5'd0, 0, 0, 1'b0, 4'd10, 11);
        repeat (3) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule